// File: doc/BRIEF.md
# Mesh Traffic Destination Generator

This block is a per-node synthetic traffic source for stressing a square two-dimensional mesh of K by K switches. It is given the node's own column and row, plus a run-time pattern code. For every packet it works out a destination address and offers it to the network port with a valid/ready handshake. Six address rules are available: uniform random, nearest neighbour, tornado, transpose, bit complement and hot spot.

The gaps between packets come from a small table of interval values that is written before traffic starts. A countdown counter loads the next table entry each time a packet is accepted. When the count expires, the destination is resolved and the packet is offered. A free-running 16-bit LFSR supplies the random draws. A draw that is not allowed is thrown away and drawn again on the next cycle. The block treats K as a power of two, and the default is 4.

Top module: `tg_traffic_gen`

## Requirements
- R1: After a synchronous reset, pkt_valid is 0 and dst_x/dst_y are 0. No packet is offered while en stays low.
- R2: Pattern code 0 (uniform) never targets the node itself. Every other node in the K by K mesh is reachable.
- R3: Pattern code 1 (neighbour) targets only a node one hop away in X or Y. At a mesh edge it targets only neighbours that exist, and each of them can occur.
- R4: Pattern code 2 (tornado) targets column (self_x + K/2 - 1) mod K in the same row.
- R5: Pattern code 3 (transpose) targets column self_y, row self_x.
- R6: Pattern code 4 (bit complement) targets the bitwise inverse of self_x and of self_y.
- R7: Pattern code 5 (hot spot) targets hot_x/hot_y. The hot node itself offers no packet while hot_tx_en is 0. When hot_tx_en is 1, it sends to its own address.
- R8: Pattern codes 6 and 7 offer no packet. Intervals still run out and are consumed.
- R9: Table entries are used in address order starting at 0 and wrap after TBL_DEPTH entries. With ready held high and a deterministic pattern (codes 2 to 5), a packet using entry value V is accepted V+3 cycles after the cycle in which en was first seen high, or after the previous acceptance.
- R10: While pkt_ready is low, pkt_valid and the destination hold steady and no countdown runs. The next interval starts only from the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Starts traffic from idle and lets the countdown run |
| pattern | input | 3 | Pattern code (0 uniform, 1 neighbour, 2 tornado, 3 transpose, 4 bit complement, 5 hot spot) |
| self_x | input | $clog2(K) | Own column |
| self_y | input | $clog2(K) | Own row |
| hot_x | input | $clog2(K) | Hot-spot target column |
| hot_y | input | $clog2(K) | Hot-spot target row |
| hot_tx_en | input | 1 | Lets the hot node transmit as well as receive |
| tbl_we | input | 1 | Interval table write strobe |
| tbl_addr | input | $clog2(TBL_DEPTH) | Interval table write address |
| tbl_data | input | IVL_W | Interval value to write |
| pkt_ready | input | 1 | Network port accepts the offered packet |
| pkt_valid | output | 1 | Packet offered |
| dst_x | output | $clog2(K) | Destination column |
| dst_y | output | $clog2(K) | Destination row |

## Verification
Two events can land in the same cycle: the acceptance of a stalled packet, and the reload of the interval counter from the table. The counter is frozen during the stall. The acceptance cycle is also the reload cycle, so a mistake here shifts the next packet by one or more cycles. The bench holds ready low for many cycles with a packet pending and checks that the outputs hold still and that nothing else is offered. It then releases ready and requires the next acceptance exactly V+3 cycles later, using the next table entry.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [2:0] {
    PAT_UNIFORM   = 3'd0,
    PAT_NEIGH     = 3'd1,
    PAT_TORNADO   = 3'd2,
    PAT_TRANSPOSE = 3'd3,
    PAT_BITCOMP   = 3'd4,
    PAT_HOTSPOT   = 3'd5
  } tg_pat_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DRAW  = 2'd2,
    ST_SEND  = 2'd3
  } tg_state_e;
endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] rnd
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) s_q <= SEED[W-1:0];
    else     s_q <= {1'b0, s_q[W-1:1]} ^ (s_q[0] ? TAPS[W-1:0] : '0);
  end

  assign rnd = s_q;

  // R2: the random source must never lock up in the all-zero state
  a_r2_lfsr_alive: assert property (@(posedge clk) disable iff (rst) s_q != '0)
    else $error("lfsr reached zero");
endmodule

// File: rtl/tg_dest_rule.sv
module tg_dest_rule import tg_pkg::*; #(
  parameter int K  = 4,
  parameter int CW = $clog2(K)
) (
  input  logic [2:0]    pattern,
  input  logic [CW-1:0] self_x,
  input  logic [CW-1:0] self_y,
  input  logic [CW-1:0] hot_x,
  input  logic [CW-1:0] hot_y,
  input  logic          hot_tx_en,
  input  logic [15:0]   rnd,
  output logic [CW-1:0] cand_x,
  output logic [CW-1:0] cand_y,
  output logic          cand_ok,
  output logic          cand_skip
);
  localparam logic [CW-1:0] TORN_OFS = CW'(K/2 - 1);
  localparam logic [CW-1:0] EDGE_HI  = CW'(K - 1);

  logic [1:0] dir;
  assign dir = rnd[2*CW+1 -: 2];

  always_comb begin
    cand_x    = self_x;
    cand_y    = self_y;
    cand_ok   = 1'b0;
    cand_skip = 1'b0;
    case (pattern)
      PAT_UNIFORM: begin
        cand_x  = rnd[CW-1:0];
        cand_y  = rnd[2*CW-1:CW];
        cand_ok = !((rnd[CW-1:0] == self_x) && (rnd[2*CW-1:CW] == self_y));
      end
      PAT_NEIGH: begin
        case (dir)
          2'd0: begin cand_x = self_x + 1'b1; cand_ok = (self_x != EDGE_HI); end
          2'd1: begin cand_x = self_x - 1'b1; cand_ok = (self_x != '0);      end
          2'd2: begin cand_y = self_y + 1'b1; cand_ok = (self_y != EDGE_HI); end
          default: begin cand_y = self_y - 1'b1; cand_ok = (self_y != '0);   end
        endcase
      end
      PAT_TORNADO: begin
        cand_x  = self_x + TORN_OFS;
        cand_ok = 1'b1;
      end
      PAT_TRANSPOSE: begin
        cand_x  = self_y;
        cand_y  = self_x;
        cand_ok = 1'b1;
      end
      PAT_BITCOMP: begin
        cand_x  = ~self_x;
        cand_y  = ~self_y;
        cand_ok = 1'b1;
      end
      PAT_HOTSPOT: begin
        cand_x    = hot_x;
        cand_y    = hot_y;
        cand_ok   = hot_tx_en || (hot_x != self_x) || (hot_y != self_y);
        cand_skip = !cand_ok;
      end
      default: cand_skip = 1'b1;
    endcase
  end
endmodule

// File: rtl/tg_interval.sv
module tg_interval #(
  parameter int IVL_W = 8,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IVL_W-1:0] wdata,
  input  logic          load,
  input  logic          tick,
  output logic          expired
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [IVL_W-1:0] mem [DEPTH];
  logic [IVL_W-1:0] rd_q;
  logic [AW-1:0]    ptr_q;
  logic [IVL_W-1:0] cnt_q;

  // plain synchronous port pair so a block RAM can hold the table
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[ptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= rd_q;
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  // R10: without a load or a tick the remaining count is frozen
  a_r10_count_frozen: assert property (@(posedge clk) disable iff (rst)
      (!load && !tick) |=> $stable(cnt_q))
    else $error("interval count moved while paused");

  // R9: the pointer walks the table one entry per load and wraps
  a_r9_ptr_step: assert property (@(posedge clk) disable iff (rst)
      load |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)))
    else $error("table pointer skipped");
endmodule

// File: rtl/tg_traffic_gen.sv
module tg_traffic_gen import tg_pkg::*; #(
  parameter int          K         = 4,
  parameter int          IVL_W     = 8,
  parameter int          TBL_DEPTH = 8,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int         CW        = $clog2(K),
  localparam int         AW        = $clog2(TBL_DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       pattern,
  input  logic [CW-1:0]    self_x,
  input  logic [CW-1:0]    self_y,
  input  logic [CW-1:0]    hot_x,
  input  logic [CW-1:0]    hot_y,
  input  logic             hot_tx_en,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_addr,
  input  logic [IVL_W-1:0] tbl_data,
  input  logic             pkt_ready,
  output logic             pkt_valid,
  output logic [CW-1:0]    dst_x,
  output logic [CW-1:0]    dst_y
);
  tg_state_e     st_q;
  logic [2:0]    mode_q;
  logic [15:0]   rnd;
  logic [CW-1:0] cand_x, cand_y;
  logic          cand_ok, cand_skip;
  logic          expired, load, tick;

  tg_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .rnd(rnd)
  );

  tg_dest_rule #(.K(K), .CW(CW)) u_rule (
    .pattern(pattern), .self_x(self_x), .self_y(self_y),
    .hot_x(hot_x), .hot_y(hot_y), .hot_tx_en(hot_tx_en), .rnd(rnd),
    .cand_x(cand_x), .cand_y(cand_y), .cand_ok(cand_ok), .cand_skip(cand_skip)
  );

  tg_interval #(.IVL_W(IVL_W), .DEPTH(TBL_DEPTH), .AW(AW)) u_ivl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_data),
    .load(load), .tick(tick), .expired(expired)
  );

  always_comb begin
    load = 1'b0;
    tick = 1'b0;
    case (st_q)
      ST_IDLE:  load = en;
      ST_COUNT: tick = en && !expired;
      ST_DRAW:  load = cand_skip;
      ST_SEND:  load = pkt_ready;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      pkt_valid <= 1'b0;
      dst_x     <= '0;
      dst_y     <= '0;
      mode_q    <= '0;
    end else begin
      case (st_q)
        ST_IDLE:  if (en) st_q <= ST_COUNT;
        ST_COUNT: if (en && expired) st_q <= ST_DRAW;
        ST_DRAW: begin
          if (cand_skip) begin
            st_q <= ST_COUNT;
          end else if (cand_ok) begin
            dst_x     <= cand_x;
            dst_y     <= cand_y;
            mode_q    <= pattern;
            pkt_valid <= 1'b1;
            st_q      <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (pkt_ready) begin
            pkt_valid <= 1'b0;
            st_q      <= ST_COUNT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: an offered packet stays put until it is taken
  a_r10_hold_offer: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(dst_x) && $stable(dst_y)))
    else $error("offer changed under backpressure");

  // R2: uniform traffic never loops back to the source
  a_r2_not_self: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && mode_q == 3'(PAT_UNIFORM)) |-> !(dst_x == self_x && dst_y == self_y))
    else $error("uniform picked own node");

  // R3: neighbour traffic is exactly one hop away
  a_r3_one_hop: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && mode_q == 3'(PAT_NEIGH)) |->
      ((dst_x == self_x && ({1'b0, dst_y} == {1'b0, self_y} + 1'b1 ||
                             {1'b0, self_y} == {1'b0, dst_y} + 1'b1)) ||
       (dst_y == self_y && ({1'b0, dst_x} == {1'b0, self_x} + 1'b1 ||
                             {1'b0, self_x} == {1'b0, dst_x} + 1'b1))))
    else $error("neighbour destination not adjacent");

  // R7: hot-spot traffic goes to the target, and a silent hot node offers nothing
  a_r7_hot_target: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && mode_q == 3'(PAT_HOTSPOT)) |->
      (dst_x == hot_x && dst_y == hot_y && (hot_tx_en || hot_x != self_x || hot_y != self_y)))
    else $error("hot-spot offer wrong");

  // R4: tornado keeps the row
  a_r4_same_row: assert property (@(posedge clk) disable iff (rst)
      (pkt_valid && mode_q == 3'(PAT_TORNADO)) |-> (dst_y == self_y))
    else $error("tornado changed row");
endmodule

// File: tb/tg_traffic_gen_tb.sv
`timescale 1ns/1ps
module tg_traffic_gen_tb;
  localparam int K = 4;
  localparam int CW = 2;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [2:0] pattern = 3'd0;
  logic [CW-1:0] self_x = '0, self_y = '0, hot_x = '0, hot_y = '0;
  logic hot_tx_en = 1'b0;
  logic tbl_we = 1'b0;
  logic [2:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic pkt_ready = 1'b1;
  logic pkt_valid;
  logic [CW-1:0] dst_x, dst_y;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int hs_cnt = 0;
  int hs_cyc [0:1023];
  logic [CW-1:0] hs_x [0:1023];
  logic [CW-1:0] hs_y [0:1023];
  int tbl [0:DEPTH-1] = '{3, 0, 5, 1, 2, 4, 0, 6};

  tg_traffic_gen #(.K(K), .IVL_W(8), .TBL_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .en(en), .pattern(pattern),
    .self_x(self_x), .self_y(self_y), .hot_x(hot_x), .hot_y(hot_y),
    .hot_tx_en(hot_tx_en), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .pkt_ready(pkt_ready), .pkt_valid(pkt_valid),
    .dst_x(dst_x), .dst_y(dst_y)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && pkt_valid && pkt_ready && hs_cnt < 1024) begin
      hs_cyc[hs_cnt] = cyc;
      hs_x[hs_cnt]   = dst_x;
      hs_y[hs_cnt]   = dst_y;
      hs_cnt = hs_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick_drive();
    @(posedge clk); #2;
  endtask

  task automatic do_reset();
    tick_drive();
    rst = 1'b1; en = 1'b0; pkt_ready = 1'b1;
    repeat (3) tick_drive();
    rst = 1'b0;
    tick_drive();
  endtask

  task automatic wait_hs(input int target, input int limit);
    for (int i = 0; i < limit && hs_cnt < target; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 valid after reset", int'(pkt_valid), 0);
    chk(dst_x == 0 && dst_y == 0, "R1 dst after reset", int'({dst_x, dst_y}), 0);
    for (int i = 0; i < DEPTH; i++) begin
      tick_drive();
      tbl_we = 1'b1; tbl_addr = 3'(i); tbl_data = 8'(tbl[i]);
    end
    tick_drive();
    tbl_we = 1'b0;
    repeat (20) tick_drive();
    chk(hs_cnt == 0, "R1 quiet while en low", hs_cnt, 0);
  endtask

  task automatic t_fixed(input logic [2:0] code, input int sx, input int sy,
                         input int ex, input int ey, input string req, input int n);
    int base, c0, bad_addr, bad_gap;
    do_reset();
    pattern = code; self_x = CW'(sx); self_y = CW'(sy);
    base = hs_cnt;
    tick_drive();
    en = 1'b1; c0 = cyc;
    wait_hs(base + n, 400);
    chk(hs_cnt == base + n, {req, " packet count"}, hs_cnt - base, n);
    bad_addr = 0; bad_gap = 0;
    for (int j = 0; j < n; j++) begin
      int prev, exp_gap;
      if (j == 0) prev = c0; else prev = hs_cyc[base + j - 1];
      exp_gap = tbl[j % DEPTH] + 3;
      if (hs_x[base + j] != CW'(ex) || hs_y[base + j] != CW'(ey)) bad_addr++;
      if (hs_cyc[base + j] - prev != exp_gap) begin
        bad_gap++;
        $display("FAIL R9 gap packet %0d actual=%0d expected=%0d", j, hs_cyc[base + j] - prev, exp_gap);
      end
    end
    chk(bad_addr == 0, {req, " destination"}, int'({hs_x[base], hs_y[base]}), (ex << CW) | ey);
    chk(bad_gap == 0, "R9 interval order and spacing", bad_gap, 0);
  endtask

  task automatic t_uniform();
    int base, selfhits;
    bit [15:0] seen;
    do_reset();
    pattern = 3'd0; self_x = 2'd2; self_y = 2'd1;
    base = hs_cnt;
    tick_drive(); en = 1'b1;
    wait_hs(base + 300, 20000);
    chk(hs_cnt == base + 300, "R2 uniform packet count", hs_cnt - base, 300);
    selfhits = 0; seen = '0;
    for (int j = base; j < hs_cnt; j++) begin
      if (hs_x[j] == self_x && hs_y[j] == self_y) selfhits++;
      seen[{hs_x[j], hs_y[j]}] = 1'b1;
    end
    chk(selfhits == 0, "R2 uniform hit own node", selfhits, 0);
    chk($countones(seen) == 15, "R2 uniform coverage of other nodes", $countones(seen), 15);
  endtask

  task automatic t_neigh(input int sx, input int sy, input int exp_cnt);
    int base, bad;
    bit [15:0] seen;
    do_reset();
    pattern = 3'd1; self_x = CW'(sx); self_y = CW'(sy);
    base = hs_cnt;
    tick_drive(); en = 1'b1;
    wait_hs(base + 80, 8000);
    bad = 0; seen = '0;
    for (int j = base; j < hs_cnt; j++) begin
      int dx, dy;
      dx = int'(hs_x[j]) - sx; dy = int'(hs_y[j]) - sy;
      if (!((dx == 0 && (dy == 1 || dy == -1)) || (dy == 0 && (dx == 1 || dx == -1)))) bad++;
      seen[{hs_x[j], hs_y[j]}] = 1'b1;
    end
    chk(hs_cnt == base + 80 && bad == 0, "R3 neighbour one hop", bad, 0);
    chk($countones(seen) == exp_cnt, "R3 neighbour set", $countones(seen), exp_cnt);
  endtask

  task automatic t_silent(input logic [2:0] code, input string req);
    int base;
    do_reset();
    pattern = code;
    base = hs_cnt;
    tick_drive(); en = 1'b1;
    repeat (300) tick_drive();
    chk(hs_cnt == base && pkt_valid == 1'b0, req, hs_cnt - base, 0);
  endtask

  task automatic t_hot();
    hot_x = 2'd0; hot_y = 2'd1; hot_tx_en = 1'b0;
    t_fixed(3'd5, 2, 3, 0, 1, "R7 hot-spot target", 4);
    self_x = 2'd0; self_y = 2'd1;
    do_reset();
    pattern = 3'd5;
    begin
      int base;
      base = hs_cnt;
      tick_drive(); en = 1'b1;
      repeat (300) tick_drive();
      chk(hs_cnt == base, "R7 hot node silent", hs_cnt - base, 0);
    end
    hot_tx_en = 1'b1;
    t_fixed(3'd5, 0, 1, 0, 1, "R7 hot node self send", 3);
    hot_tx_en = 1'b0;
  endtask

  task automatic t_backpressure();
    int base, moved;
    logic [CW-1:0] hx, hy;
    do_reset();
    pattern = 3'd2; self_x = 2'd3; self_y = 2'd0;
    pkt_ready = 1'b0;
    base = hs_cnt;
    tick_drive(); en = 1'b1;
    for (int i = 0; i < 50 && !pkt_valid; i++) tick_drive();
    hx = dst_x; hy = dst_y; moved = 0;
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (!pkt_valid || dst_x != hx || dst_y != hy) moved++;
    end
    chk(moved == 0, "R10 offer held under stall", moved, 0);
    chk(hx == 2'd0 && hy == 2'd0, "R4 tornado wrap", int'({hx, hy}), 0);
    tick_drive(); pkt_ready = 1'b1;
    wait_hs(base + 2, 100);
    chk(hs_cnt == base + 2, "R10 packets after release", hs_cnt - base, 2);
    chk(hs_cyc[base + 1] - hs_cyc[base] == tbl[1] + 3, "R10 next interval from accept",
        hs_cyc[base + 1] - hs_cyc[base], tbl[1] + 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    t_reset();
    t_fixed(3'd2, 1, 2, 2, 2, "R4 tornado", 10);
    t_fixed(3'd3, 1, 3, 3, 1, "R5 transpose", 5);
    t_fixed(3'd4, 1, 2, 2, 1, "R6 bit complement", 5);
    t_uniform();
    t_neigh(0, 0, 2);
    t_neigh(1, 1, 4);
    t_hot();
    t_silent(3'd6, "R8 code 6 silent");
    t_silent(3'd7, "R8 code 7 silent");
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule